// File: doc/BRIEF.md
# Parallel-Output Look-Ahead Pseudo-Random Bit Generator

This block produces a stream of uniformly distributed pseudo-random nibbles. Its core is an 18-bit Fibonacci shift register built on the primitive trinomial x^18 + x^11 + 1. Each clock, a chain of single-step stages jumps the register four positions ahead. The four freshly generated bits come out together as one unsigned 4-bit word. Several instances with different seeds can be summed in an adder tree to approximate Gaussian noise.

The seed is a design-time parameter. Bit k of the seed initialises state register k. An all-zero seed would freeze the register, so it is replaced by the value 1. Width, tap position and bits per clock are parameters; the defaults give the 18-bit, 4-bit-per-clock generator.

Top module: `lfsr_leap`

## Requirements
- R1: While `rst_n` is low, the state holds the effective seed, and `rnd_o` shows its four least significant bits. Asserting `rst_n` takes effect at once, with no clock edge needed.
- R2: On each rising clock edge out of reset, the state advances exactly four single steps. One single step maps state s to {s[16:0], s[17] ^ s[10]}.
- R3: A seed parameter of zero is replaced by the value 1. The state never becomes zero.
- R4: `rnd_o` equals state bits [3:0]. Bit 0 is the bit made by the last of the four steps, and bit 3 is the bit made by the first.
- R5: Because the step count per clock is coprime to 2^WIDTH - 1, the state returns to the seed after exactly 2^WIDTH - 1 clocks, so `rnd_o` repeats with that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, reloads the seed |
| rnd_o | output | 4 | Four newest pseudo-random bits, unsigned |

## Verification
On every cycle, the assertions check four things: the seed is present at the first edge after reset, the upper state bits carry the lower bits four places up, the first-step feedback lands in bit 3, and the state is never zero. Only the bench's scenarios can show that the output nibble sequence matches a bit-serial model over thousands of clocks. The same holds for the effect of an asynchronous reset in mid-run, the substitution of a zero seed, and the exact period. The period is shown on a 7-bit configuration with trinomial x^7 + x^6 + 1, whose period of 127 clocks fits in a short run.

// File: rtl/lfsr_leap_pkg.sv
package lfsr_leap_pkg;
  // Default geometry: degree-18 trinomial with its inner tap at 11,
  // four single steps merged into each clock.
  localparam int DEF_WIDTH = 18;
  localparam int DEF_TAP   = 11;
  localparam int DEF_STEPS = 4;
  localparam int DEF_SEED  = 33072;
endpackage

// File: rtl/lfsr_leap_next.sv
// Combinational look-ahead: STEPS copies of the single-step map, chained.
// Each stage costs one two-input XOR; the rest is wiring.
module lfsr_leap_next #(
  parameter int WIDTH = 18,
  parameter int TAP   = 11,
  parameter int STEPS = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] stage [STEPS+1];

  assign stage[0] = cur_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign stage[g+1] = {stage[g][WIDTH-2:0],
                         stage[g][WIDTH-1] ^ stage[g][TAP-1]};
  end

  assign nxt_o = stage[STEPS];
endmodule

// File: rtl/lfsr_leap_state.sv
// State bank: asynchronous active-low reset to the effective seed.
module lfsr_leap_state #(
  parameter int WIDTH = 18,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= INIT;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/lfsr_leap.sv
module lfsr_leap
  import lfsr_leap_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH,
  parameter int TAP   = DEF_TAP,
  parameter int STEPS = DEF_STEPS,
  parameter logic [WIDTH-1:0] SEED = WIDTH'(DEF_SEED)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [STEPS-1:0] rnd_o
);
  // R3: a zero seed would lock the register; substitute 1.
  localparam logic [WIDTH-1:0] SEED_EFF = (SEED == '0) ? WIDTH'(1) : SEED;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  lfsr_leap_next #(.WIDTH(WIDTH), .TAP(TAP), .STEPS(STEPS)) u_next (
    .cur_i (state_q),
    .nxt_o (state_d)
  );

  lfsr_leap_state #(.WIDTH(WIDTH), .INIT(SEED_EFF)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  // R4: newest bits sit at the bottom of the state.
  assign rnd_o = state_q[STEPS-1:0];

  // R1: first edge after release still sees the seed in the bank.
  a_r1_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> state_q == SEED_EFF);

  // R2: the untouched part of the state moves up by STEPS places.
  a_r2_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q[WIDTH-1:STEPS] == $past(state_q[WIDTH-1-STEPS:0]));

  // R2/R4: the bit from the first step, computed from the old state, ends in bit STEPS-1.
  a_r2_first_tap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q[STEPS-1] == $past(state_q[WIDTH-1] ^ state_q[TAP-1]));

  // R3: lock-up state never reached.
  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: tb/lfsr_leap_bench.sv
module lfsr_leap_bench;
  localparam logic [17:0] BIG_SEED   = 18'd33072;
  localparam logic [6:0]  SMALL_SEED = 7'h2B;
  localparam int          SMALL_PER  = 127;
  localparam int          RUN        = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] out_big, out_small, out_zero;

  lfsr_leap u_lfsr_leap (.clk(clk), .rst_n(rst_n), .rnd_o(out_big));
  lfsr_leap #(.WIDTH(7), .TAP(6), .STEPS(4), .SEED(SMALL_SEED)) u_small (
    .clk(clk), .rst_n(rst_n), .rnd_o(out_small));
  lfsr_leap #(.WIDTH(7), .TAP(6), .STEPS(4), .SEED(7'd0)) u_zero (
    .clk(clk), .rst_n(rst_n), .rnd_o(out_zero));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [17:0] m_big;
  logic [6:0]  m_small, m_zero;
  logic [3:0]  hist [400];

  function automatic logic [17:0] adv18(logic [17:0] s);
    for (int i = 0; i < 4; i++) s = {s[16:0], s[17] ^ s[10]};
    return s;
  endfunction

  function automatic logic [6:0] adv7(logic [6:0] s);
    for (int i = 0; i < 4; i++) s = {s[5:0], s[6] ^ s[5]};
    return s;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cycles(int n, bit record);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      m_big   = adv18(m_big);
      m_small = adv7(m_small);
      m_zero  = adv7(m_zero);
      chk("R2/R4 big", out_big, m_big[3:0]);
      chk("R2/R4 small", out_small, m_small[3:0]);
      chk("R3 zero-seed run", out_zero, m_zero[3:0]);
      if (record && i < 400) hist[i] = out_small;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset big", out_big, BIG_SEED[3:0]);
    chk("R1 reset small", out_small, SMALL_SEED[3:0]);
    chk("R3 zero seed replaced", out_zero, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    m_big = BIG_SEED; m_small = SMALL_SEED; m_zero = 7'd1;
    run_cycles(RUN, 1'b1);
    // R5: period of 127 clocks on the 7-bit configuration.
    chk("R5 back to seed", hist[SMALL_PER-1], SMALL_SEED[3:0]);
    for (int i = 0; i + SMALL_PER < 400; i++)
      chk("R5 periodic", hist[i+SMALL_PER], hist[i]);
    // R1: asynchronous reset in mid-run, no clock edge needed.
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async big", out_big, BIG_SEED[3:0]);
    chk("R1 async small", out_small, SMALL_SEED[3:0]);
    chk("R1 async zero", out_zero, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    m_big = BIG_SEED; m_small = SMALL_SEED; m_zero = 7'd1;
    run_cycles(50, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule